// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash and turns one high-level request into the fixed series of bus write and read cycles that the flash command set expects. A requester presents an operation code, a target address, a data word and a word count under a valid/ready handshake. The block then plays the matching script on a simple bus of address, write data, write strobe and read strobe, and hands back every word it reads. The supported scripts are identification read, return to read mode, single-word program, sector erase, whole-chip erase, common flash interface (CFI) query and buffered program.

Command addresses are word addresses. A mode input selects a 16-bit bus, where each command word address is doubled to form the byte address, or an 8-bit bus, where it is used as is. Target addresses are bus addresses and are never scaled. For buffered programming the words to load are pulled one at a time from a separate data input, so the block holds no buffer of its own. A write-protect input blocks every request that would change the flash contents. The block does not handle the flash's electrical timing, its ready/busy pin or completion polling.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, `status` is 0 (idle), both strobes are low and no `rd_valid` or `req_err` pulse is present.
- R2: The identification, program and both erase scripts begin with two unlock writes: 0xAA to command word 0x555, then 0x55 to command word 0x2AA.
- R3: Identification read is the unlock, then 0x90 to word 0x555, then four read cycles at words 0x000, 0x001, 0x00E and 0x00F. Each word read is returned on `rd_data` with a one-cycle `rd_valid` pulse, in the same order as the read cycles.
- R4: Single-word program (op 2) is the unlock, then 0xA0 to word 0x555, then one write of `req_wdata` to `req_addr`.
- R5: Sector erase (op 3) and chip erase (op 4) are the unlock, 0x80 to word 0x555 and a second unlock. A sector erase then writes 0x30 to `req_addr`. A chip erase instead writes 0x10 to word 0x555.
- R6: Return to read mode (op 1) is one write of 0xF0 to bus address 0. CFI query (op 5) is one write of 0x98 to word 0x055 with no unlock, followed by read cycles at words 0x010 to 0x013 in rising order.
- R7: Buffered program (op 6) with count N runs in this order: the unlock, 0x25 to `req_addr`, N-1 to `req_addr`, then N data writes of successive `buf_data` words to `req_addr` plus i word steps, then 0x29 to the address of the last word. Each consumed word is acknowledged by a one-cycle `buf_pop`.
- R8: With `wide_mode`=1 a command word address W appears on `bus_addr` as W shifted left by one. With `wide_mode`=0 it appears as W. In buffered program one word step is 2 when `wide_mode`=1 and 1 when `wide_mode`=0.
- R9: Every bus cycle holds exactly one strobe high for `strobe_len` clocks, with 0 treated as 1. Address and data stay stable while the strobe is high. Consecutive cycles of a script are separated by exactly one clock with both strobes low, and the two strobes are never high together.
- R10: `req_ready` is 0 from the clock after a request is accepted until the clock after the final idle clock of its script. Requests presented in that span are ignored and cause no bus cycles.
- R11: While `wr_protect` is 1 and no script is running, `status` reads 2. Program, erase and buffered program requests are then refused with a one-cycle `req_err` pulse and no bus cycle. Identification, CFI and return to read mode still run. While a script runs, `status` reads 1.
- R12: A buffered program with count 0, or with a count above MAXBUF (default 16), and op code 7 are all refused with a `req_err` pulse and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Operation code: 0 ident, 1 read mode, 2 program, 3 sector erase, 4 chip erase, 5 CFI, 6 buffered program |
| req_addr | input | AW | Target bus address |
| req_wdata | input | DW | Word for single program |
| req_count | input | CW | Word count for buffered program |
| wide_mode | input | 1 | 1: 16-bit bus address scaling, 0: 8-bit |
| wr_protect | input | 1 | Refuse content-changing requests |
| strobe_len | input | LW | Strobe width in clocks (0 acts as 1) |
| buf_data | input | DW | Next word to load in buffered program |
| buf_pop | output | 1 | One `buf_data` word was taken |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | DW | Flash bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DW | Flash bus read data |
| rd_valid | output | 1 | `rd_data` holds a word read back |
| rd_data | output | DW | Word read back |
| req_err | output | 1 | Request refused |
| status | output | 2 | 0 idle, 1 busy, 2 write-protected |

## Verification
The delicate coincidence is a new request that is still held high on the final idle clock of a running script. That is the same clock on which the sequencer decides it is done. The bench holds a second request high through a whole program script and drops it in the first clock where `req_ready` is seen high. It then checks that only the four program cycles reached the bus. A second collision is the read capture and the step advance in a read script: every read word must come back exactly once and in order, whatever the strobe length. The bench sweeps strobe lengths from 0 upward and matches each returned word against the value its bus model gives for that address.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDENT   = 3'd0,
        OP_RDMODE  = 3'd1,
        OP_PROG    = 3'd2,
        OP_SERASE  = 3'd3,
        OP_CERASE  = 3'd4,
        OP_CFI     = 3'd5,
        OP_BUFPROG = 3'd6,
        OP_RSVD    = 3'd7
    } nor_op_e;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'd0,
        STAT_BUSY = 2'd1,
        STAT_PROT = 2'd2
    } nor_stat_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STB  = 2'd1,
        S_GAP  = 2'd2
    } seq_state_e;

    // where a step takes its address from
    typedef enum logic [1:0] {
        A_CMD      = 2'd0,
        A_TGT      = 2'd1,
        A_BUF_I    = 2'd2,
        A_BUF_LAST = 2'd3
    } addr_sel_e;

    // where a step takes its write data from
    typedef enum logic [1:0] {
        D_CMD   = 2'd0,
        D_WDATA = 2'd1,
        D_CNT   = 2'd2,
        D_BUF   = 2'd3
    } data_sel_e;

    typedef struct packed {
        logic        rd;
        logic        pull;
        addr_sel_e   asel;
        data_sel_e   dsel;
        logic [11:0] word;
        logic [7:0]  cmd;
    } step_desc_t;

    localparam logic [11:0] WA_MAIN = 12'h555;
    localparam logic [11:0] WA_ALT  = 12'h2AA;
    localparam logic [11:0] WA_QRY  = 12'h055;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_RDMODE = 8'hF0;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ERSET  = 8'h80;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_QRY    = 8'h98;
    localparam logic [7:0] C_BLOAD  = 8'h25;
    localparam logic [7:0] C_BCONF  = 8'h29;

    function automatic step_desc_t cmd_step(logic [11:0] w, logic [7:0] c);
        step_desc_t s;
        s = '{rd: 1'b0, pull: 1'b0, asel: A_CMD, dsel: D_CMD, word: w, cmd: c};
        return s;
    endfunction

    function automatic step_desc_t rd_step(logic [11:0] w);
        step_desc_t s;
        s = '{rd: 1'b1, pull: 1'b0, asel: A_CMD, dsel: D_CMD, word: w, cmd: 8'h00};
        return s;
    endfunction

    function automatic step_desc_t tgt_step(data_sel_e d, logic [7:0] c);
        step_desc_t s;
        s = '{rd: 1'b0, pull: 1'b0, asel: A_TGT, dsel: d, word: 12'h000, cmd: c};
        return s;
    endfunction

    function automatic step_desc_t key_step(logic second);
        return second ? cmd_step(WA_ALT, C_KEY2) : cmd_step(WA_MAIN, C_KEY1);
    endfunction

    function automatic logic [11:0] ident_word(logic [1:0] i);
        case (i)
            2'd0:    return 12'h000;
            2'd1:    return 12'h001;
            2'd2:    return 12'h00E;
            default: return 12'h00F;
        endcase
    endfunction

    function automatic logic is_modifying(nor_op_e op);
        return (op == OP_PROG) || (op == OP_SERASE) ||
               (op == OP_CERASE) || (op == OP_BUFPROG);
    endfunction

    function automatic logic [15:0] script_len(nor_op_e op, logic [15:0] cnt);
        case (op)
            OP_IDENT:   return 16'd7;
            OP_RDMODE:  return 16'd1;
            OP_PROG:    return 16'd4;
            OP_SERASE:  return 16'd6;
            OP_CERASE:  return 16'd6;
            OP_CFI:     return 16'd5;
            OP_BUFPROG: return cnt + 16'd5;
            default:    return 16'd0;
        endcase
    endfunction

    function automatic step_desc_t script_step(nor_op_e op, logic [15:0] k, logic [15:0] cnt);
        step_desc_t s;
        logic [15:0] j;
        s = cmd_step(12'h000, 8'h00);
        j = k - 16'd1;
        case (op)
            OP_IDENT: begin
                if (k < 16'd2)       s = key_step(k[0]);
                else if (k == 16'd2) s = cmd_step(WA_MAIN, C_IDENT);
                else                 s = rd_step(ident_word(2'(k - 16'd3)));
            end
            OP_RDMODE: s = cmd_step(12'h000, C_RDMODE);
            OP_PROG: begin
                if (k < 16'd2)       s = key_step(k[0]);
                else if (k == 16'd2) s = cmd_step(WA_MAIN, C_PROG);
                else                 s = tgt_step(D_WDATA, 8'h00);
            end
            OP_SERASE, OP_CERASE: begin
                if (k < 16'd2)       s = key_step(k[0]);
                else if (k == 16'd2) s = cmd_step(WA_MAIN, C_ERSET);
                else if (k < 16'd5)  s = key_step(k == 16'd4);
                else if (op == OP_SERASE) s = tgt_step(D_CMD, C_SECT);
                else                 s = cmd_step(WA_MAIN, C_CHIP);
            end
            OP_CFI: begin
                if (k == 16'd0) s = cmd_step(WA_QRY, C_QRY);
                else            s = rd_step(12'h010 + 12'(j));
            end
            OP_BUFPROG: begin
                if (k < 16'd2)       s = key_step(k[0]);
                else if (k == 16'd2) s = tgt_step(D_CMD, C_BLOAD);
                else if (k == 16'd3) s = tgt_step(D_CNT, 8'h00);
                else if (k < cnt + 16'd4) begin
                    s = tgt_step(D_BUF, 8'h00);
                    s.asel = A_BUF_I;
                    s.pull = 1'b1;
                end else begin
                    s = tgt_step(D_CMD, C_BCONF);
                    s.asel = A_BUF_LAST;
                end
            end
            default: s = cmd_step(12'h000, 8'h00);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_req_check.sv
module nor_req_check
    import nor_seq_pkg::*;
#(
    parameter int CW     = 8,
    parameter int MAXBUF = 16
) (
    input  nor_op_e         op,
    input  logic [CW-1:0]   count,
    input  logic            wprot,
    output logic            bad
);
    logic cnt_bad;

    always_comb begin
        cnt_bad = (count == '0) || (count > CW'(MAXBUF));
        bad = (op == OP_RSVD)
            || (wprot && is_modifying(op))
            || ((op == OP_BUFPROG) && cnt_bad);
    end
endmodule

// File: rtl/nor_step_map.sv
module nor_step_map
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int CW = 8,
    parameter int SW = 5
) (
    input  nor_op_e         op,
    input  logic [SW-1:0]   k,
    input  logic [CW-1:0]   count,
    input  logic [AW-1:0]   tgt,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   buf_data,
    input  logic            wide,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   data,
    output logic            rd,
    output logic            pull
);
    step_desc_t    s;
    logic [SW-1:0] idx;
    logic [AW-1:0] off;
    logic [AW-1:0] wa;
    logic [DW-1:0] cmd_ext;

    // the command byte is placed in the low lane whatever the bus width
    generate
        if (DW > 8) begin : g_cmd_wide
            assign cmd_ext = {{(DW-8){1'b0}}, s.cmd};
        end else begin : g_cmd_narrow
            assign cmd_ext = s.cmd[DW-1:0];
        end
    endgenerate

    always_comb begin
        s   = script_step(op, 16'(k), 16'(count));
        idx = (s.asel == A_BUF_LAST) ? (SW'(count) - 1'b1) : (k - SW'(4));
        off = wide ? (AW'(idx) << 1) : AW'(idx);
        wa  = wide ? (AW'(s.word) << 1) : AW'(s.word);
        case (s.asel)
            A_CMD:   addr = wa;
            A_TGT:   addr = tgt;
            default: addr = tgt + off;
        endcase
        case (s.dsel)
            D_CMD:   data = cmd_ext;
            D_WDATA: data = wdata;
            D_CNT:   data = DW'(count) - 1'b1;
            default: data = buf_data;
        endcase
        if (s.rd) data = '0;
        rd   = s.rd;
        pull = s.pull;
    end
endmodule

// File: rtl/nor_strobe_timer.sv
module nor_strobe_timer #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] len,
    output logic          done
);
    logic [LW-1:0] cnt;
    logic [LW-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= (len == '0) ? '0 : len - 1'b1;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == lim);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int LW     = 4,
    parameter int MAXBUF = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [CW-1:0] req_count,
    input  logic          wide_mode,
    input  logic          wr_protect,
    input  logic [LW-1:0] strobe_len,
    input  logic [DW-1:0] buf_data,
    output logic          buf_pop,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    input  logic [DW-1:0] bus_rdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          req_err,
    output logic [1:0]    status
);
    localparam int SW = $clog2(MAXBUF + 6);

    typedef struct packed {
        nor_op_e        op;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [CW-1:0]  count;
        logic           wide;
    } req_t;

    req_t          in_req, req_q, cur_req;
    seq_state_e    st_q;
    logic [SW-1:0] step_q, last_q, k_sel;
    logic [LW-1:0] len_q, tim_len;
    logic          bad, accept, advance, tim_start, tim_done;
    logic          m_rd, m_pull;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;

    assign in_req = '{op: nor_op_e'(req_op), addr: req_addr, wdata: req_wdata,
                      count: req_count, wide: wide_mode};

    // while idle the incoming request feeds the step map for step 0
    assign cur_req   = (st_q == S_IDLE) ? in_req : req_q;
    assign k_sel     = (st_q == S_IDLE) ? '0 : step_q + 1'b1;
    assign accept    = (st_q == S_IDLE) && req_valid && !bad;
    assign advance   = (st_q == S_GAP) && (step_q != last_q);
    assign tim_start = accept || advance;
    assign tim_len   = accept ? strobe_len : len_q;

    nor_req_check #(.CW(CW), .MAXBUF(MAXBUF)) u_check (
        .op    (in_req.op),
        .count (req_count),
        .wprot (wr_protect),
        .bad   (bad)
    );

    nor_step_map #(.AW(AW), .DW(DW), .CW(CW), .SW(SW)) u_map (
        .op       (cur_req.op),
        .k        (k_sel),
        .count    (cur_req.count),
        .tgt      (cur_req.addr),
        .wdata    (cur_req.wdata),
        .buf_data (buf_data),
        .wide     (cur_req.wide),
        .addr     (m_addr),
        .data     (m_data),
        .rd       (m_rd),
        .pull     (m_pull)
    );

    nor_strobe_timer #(.LW(LW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (tim_start),
        .len   (tim_len),
        .done  (tim_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            req_q     <= '0;
            step_q    <= '0;
            last_q    <= '0;
            len_q     <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            buf_pop   <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            req_err   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            req_err  <= 1'b0;
            buf_pop  <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (req_valid && bad) begin
                        req_err <= 1'b1;
                    end else if (accept) begin
                        req_q     <= in_req;
                        len_q     <= strobe_len;
                        step_q    <= '0;
                        last_q    <= SW'(script_len(in_req.op, 16'(req_count))) - 1'b1;
                        bus_addr  <= m_addr;
                        bus_wdata <= m_data;
                        bus_we    <= !m_rd;
                        bus_re    <= m_rd;
                        buf_pop   <= m_pull;
                        st_q      <= S_STB;
                    end
                end
                S_STB: begin
                    if (tim_done) begin
                        bus_we <= 1'b0;
                        bus_re <= 1'b0;
                        if (bus_re) begin
                            rd_data  <= bus_rdata;
                            rd_valid <= 1'b1;
                        end
                        st_q <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (advance) begin
                        step_q    <= k_sel;
                        bus_addr  <= m_addr;
                        bus_wdata <= m_data;
                        bus_we    <= !m_rd;
                        bus_re    <= m_rd;
                        buf_pop   <= m_pull;
                        st_q      <= S_STB;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st_q == S_IDLE);
    assign status    = (st_q != S_IDLE) ? STAT_BUSY :
                       (wr_protect ? STAT_PROT : STAT_IDLE);
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          bus_we,
    input logic          bus_re,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          rd_valid,
    input logic          req_err,
    input logic [1:0]    status
);
    assert_excl_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

    assert_gap_before_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_we) || $rose(bus_re)) |-> $past(!bus_we && !bus_re));

    assert_hold_during_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && $past(bus_we)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> !req_ready);

    assert_ready_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (status != 2'd1));

    assert_reject_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!bus_we && !bus_re && req_ready));

    assert_read_return_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_re));

    assert_prot_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |-> req_ready);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .req_err   (req_err),
    .status    (status)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int LW = 4;
    localparam int MAXB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [CW-1:0] req_count = '0;
    logic          wide_mode = 1'b1;
    logic          wr_protect = 1'b0;
    logic [LW-1:0] strobe_len = 4'd2;
    logic [DW-1:0] buf_data;
    logic          buf_pop;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we, bus_re;
    logic [DW-1:0] bus_rdata;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          req_err;
    logic [1:0]    status;

    always #4 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .CW(CW), .LW(LW), .MAXBUF(MAXB)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_count(req_count), .wide_mode(wide_mode), .wr_protect(wr_protect),
        .strobe_len(strobe_len), .buf_data(buf_data), .buf_pop(buf_pop),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .req_err(req_err), .status(status));

    // flash model: read value derived from the address
    assign bus_rdata = bus_addr[15:0] ^ 16'hC3A5;

    logic [15:0] bufw [0:31];
    int          pop_idx = 0;
    assign buf_data = bufw[pop_idx];
    always @(posedge clk) if (buf_pop) pop_idx <= pop_idx + 1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // bus monitor
    logic [AW-1:0] mon_a [0:63];
    logic [15:0]   mon_d [0:63];
    bit            mon_r [0:63];
    int            mon_t [0:63];
    int            mon_n = 0;
    int            run_len = 0;
    int            len_bad = 0;
    int            exp_len = 1;
    bit            prev_act = 1'b0;
    logic [15:0]   rd_got [0:15];
    int            rd_n = 0;
    bit            err_seen = 1'b0;
    bit            both_hi = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (bus_we && bus_re) both_hi = 1'b1;
            if ((bus_we || bus_re) && !prev_act) begin
                if (mon_n < 64) begin
                    mon_a[mon_n] = bus_addr;
                    mon_d[mon_n] = bus_wdata;
                    mon_r[mon_n] = bus_re;
                    mon_t[mon_n] = cyc;
                    mon_n++;
                end
                run_len = 1;
            end else if (bus_we || bus_re) begin
                run_len++;
            end
            if (!(bus_we || bus_re) && prev_act && run_len != exp_len) len_bad++;
            prev_act = bus_we || bus_re;
            if (rd_valid && rd_n < 16) begin
                rd_got[rd_n] = rd_data;
                rd_n++;
            end
            if (req_err) err_seen = 1'b1;
        end
    end

    // expected script
    logic [AW-1:0] e_a [0:63];
    logic [15:0]   e_d [0:63];
    bit            e_r [0:63];
    int            e_n;

    function automatic logic [AW-1:0] sc(input logic [11:0] w, input logic wd);
        return wd ? {11'b0, w, 1'b0} : {12'b0, w};
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic [15:0] d, input bit r);
        e_a[e_n] = a; e_d[e_n] = d; e_r[e_n] = r; e_n++;
    endtask

    task automatic unlock(input logic wd);
        push(sc(12'h555, wd), 16'h00AA, 0);
        push(sc(12'h2AA, wd), 16'h0055, 0);
    endtask

    task automatic build_exp(input int op, input logic [AW-1:0] a, input logic [15:0] d,
                             input int cnt, input logic wd);
        logic [AW-1:0] stp;
        stp = wd ? 24'd2 : 24'd1;
        e_n = 0;
        case (op)
            0: begin
                unlock(wd); push(sc(12'h555, wd), 16'h0090, 0);
                push(sc(12'h000, wd), 0, 1); push(sc(12'h001, wd), 0, 1);
                push(sc(12'h00E, wd), 0, 1); push(sc(12'h00F, wd), 0, 1);
            end
            1: push(24'h0, 16'h00F0, 0);
            2: begin unlock(wd); push(sc(12'h555, wd), 16'h00A0, 0); push(a, d, 0); end
            3, 4: begin
                unlock(wd); push(sc(12'h555, wd), 16'h0080, 0); unlock(wd);
                if (op == 3) push(a, 16'h0030, 0); else push(sc(12'h555, wd), 16'h0010, 0);
            end
            5: begin
                push(sc(12'h055, wd), 16'h0098, 0);
                for (int i = 0; i < 4; i++) push(sc(12'h010 + 12'(i), wd), 0, 1);
            end
            6: begin
                unlock(wd); push(a, 16'h0025, 0); push(a, 16'(cnt - 1), 0);
                for (int i = 0; i < cnt; i++) push(a + stp * 24'(i), bufw[i], 0);
                push(a + stp * 24'(cnt - 1), 16'h0029, 0);
            end
            default: e_n = 0;
        endcase
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic compare(input string rq, input int L);
        int bad_i;
        int nr;
        chk(mon_n == e_n, rq, "bus cycle count", mon_n, e_n);
        bad_i = -1;
        for (int i = 0; i < e_n && i < mon_n; i++) begin
            if (bad_i < 0 && (mon_a[i] != e_a[i] || mon_r[i] != e_r[i] ||
                              (!e_r[i] && mon_d[i] != e_d[i]))) bad_i = i;
        end
        if (bad_i >= 0)
            chk(0, rq, $sformatf("cycle %0d addr/data", bad_i),
                {mon_a[bad_i], mon_d[bad_i]}, {e_a[bad_i], e_d[bad_i]});
        else chk(1, rq, "cycles", 0, 0);
        nr = 0;
        for (int i = 0; i < e_n; i++) begin
            if (e_r[i]) begin
                if (nr < rd_n && rd_got[nr] != (e_a[i][15:0] ^ 16'hC3A5))
                    chk(0, {rq, " R3"}, "read word", rd_got[nr], e_a[i][15:0] ^ 16'hC3A5);
                nr++;
            end
        end
        chk(rd_n == nr, rq, "read count", rd_n, nr);
        bad_i = 0;
        for (int i = 1; i < mon_n; i++)
            if (mon_t[i] - mon_t[i-1] != ((L == 0) ? 1 : L) + 1) bad_i++;
        chk(len_bad == 0 && bad_i == 0 && !both_hi, "R9", "strobe/gap errors",
            len_bad + bad_i, 0);
    endtask

    task automatic clear_mon(input int L);
        mon_n = 0; rd_n = 0; len_bad = 0; err_seen = 0; both_hi = 0;
        exp_len = (L == 0) ? 1 : L;
        pop_idx = 0;
    endtask

    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [15:0] d,
                          input int cnt, input logic wd, input int L, input logic wp,
                          input string rq);
        bit exp_err;
        int w;
        exp_err = (op == 7) || (wp && (op == 2 || op == 3 || op == 4 || op == 6)) ||
                  (op == 6 && (cnt == 0 || cnt > MAXB));
        @(negedge clk);
        clear_mon(L);
        if (exp_err) e_n = 0; else build_exp(op, a, d, cnt, wd);
        req_op = 3'(op); req_addr = a; req_wdata = d; req_count = 8'(cnt);
        wide_mode = wd; strobe_len = 4'(L); wr_protect = wp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!req_ready && w < 2000) begin @(negedge clk); w++; end
        chk(w < 2000, rq, "completion timeout", w, 0);
        repeat (2) @(negedge clk);
        chk(err_seen == exp_err, exp_err ? "R12/R11" : rq, "req_err", err_seen, exp_err);
        compare(rq, L);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int op, cnt, L;
        logic wd, wp;
        logic [AW-1:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) bufw[i] = 16'(i * 16'h1111 + 16'h0F0F);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(status == 2'd0, "R1", "status", status, 0);
        chk(!bus_we && !bus_re && !rd_valid && !req_err, "R1", "strobes/pulses",
            {bus_we, bus_re, rd_valid, req_err}, 0);

        // directed scripts, wide bus
        run_op(0, 24'h0, 16'h0, 0, 1, 2, 0, "R3 R2");
        run_op(1, 24'h0, 16'h0, 0, 1, 2, 0, "R6");
        run_op(2, 24'h012344, 16'hBEEF, 0, 1, 2, 0, "R4 R2");
        run_op(3, 24'h040000, 16'h0, 0, 1, 3, 0, "R5");
        run_op(4, 24'h0, 16'h0, 0, 1, 1, 0, "R5");
        run_op(5, 24'h0, 16'h0, 0, 1, 2, 0, "R6");
        run_op(6, 24'h000200, 16'h0, 5, 1, 2, 0, "R7");
        chk(pop_idx == 5, "R7", "buf_pop count", pop_idx, 5);
        // narrow bus scaling
        run_op(2, 24'h000301, 16'h1234, 0, 0, 2, 0, "R8");
        run_op(0, 24'h0, 16'h0, 0, 0, 1, 0, "R8 R3");
        run_op(6, 24'h000100, 16'h0, 3, 0, 1, 0, "R8 R7");
        // strobe lengths, 0 acts as 1
        run_op(5, 24'h0, 16'h0, 0, 1, 0, 0, "R9");
        run_op(0, 24'h0, 16'h0, 0, 1, 15, 0, "R9");
        // buffer bounds
        run_op(6, 24'h001000, 16'h0, MAXB, 1, 1, 0, "R7");
        run_op(6, 24'h001000, 16'h0, 0, 1, 1, 0, "R12");
        run_op(6, 24'h001000, 16'h0, MAXB + 1, 1, 1, 0, "R12");
        run_op(7, 24'h0, 16'h0, 0, 1, 1, 0, "R12");
        // write protection
        @(negedge clk); wr_protect = 1'b1; @(negedge clk);
        chk(status == 2'd2, "R11", "protected status", status, 2);
        run_op(2, 24'h10, 16'h5555, 0, 1, 1, 1, "R11");
        run_op(3, 24'h10, 16'h0, 0, 1, 1, 1, "R11");
        run_op(6, 24'h10, 16'h0, 4, 1, 1, 1, "R11");
        run_op(0, 24'h0, 16'h0, 0, 1, 1, 1, "R11 R3");
        @(negedge clk); wr_protect = 1'b0;

        // R10: request held through a running script, dropped when ready returns
        @(negedge clk);
        clear_mon(2);
        build_exp(2, 24'h000ABC, 16'h7777, 0, 1);
        req_op = 3'd2; req_addr = 24'h000ABC; req_wdata = 16'h7777; wide_mode = 1;
        strobe_len = 4'd2; req_valid = 1'b1;
        @(negedge clk);
        chk(status == 2'd1, "R11", "busy status", status, 1);
        req_op = 3'd4;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        compare("R10", 2);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            op  = int'($urandom_range(0, 7));
            cnt = int'($urandom_range(0, MAXB + 1));
            L   = int'($urandom_range(0, 5));
            wd  = 1'($urandom_range(0, 1));
            wp  = ($urandom_range(0, 3) == 0);
            a   = 24'($urandom) & 24'hFFFFFE;
            for (int i = 0; i < 32; i++) bufw[i] = 16'($urandom);
            run_op(op, a, 16'($urandom), cnt, wd, L, wp, "R2 R10 random");
        end
        @(negedge clk); wr_protect = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule